// File: doc/BRIEF.md
# Per-Line Request Serialiser for a Broadcast Coherence Home

This block sits at the home of a set of cache lines in a coherence scheme that keeps no record of which nodes hold copies. Every request that targets one of its lines arrives here. The block chooses the order in which those requests are served and sends each chosen request to every other node as a broadcast. The network between nodes may reorder traffic, so this block is the single place where the order of requests to a line is fixed.

A line becomes busy when its request is broadcast. It stays busy until a completion message returns the transaction identifier of that request. While a line is busy, newer requests to it wait in an internal buffer, in order of arrival. Requests to other lines keep flowing, up to a fixed number of lines in flight at once. When the buffer is full, the request input is stalled.

Top module: `coh_order_point`

## Requirements
- R1: After reset no broadcast is issued and `req_ready` is high.
- R2: A broadcast carries the request's line, transaction id and source node. The destination mask has bit n set for node n, and it covers every node except the source.
- R3: A request accepted on clock edge k, to an idle line with a free in-flight slot, is broadcast on the output during the cycle after edge k+1. The broadcast lasts exactly one cycle.
- R4: A request to a line that is in flight is not broadcast until a completion carrying the in-flight transaction id has been received.
- R5: While one line is blocked, a younger request to a different idle line is broadcast, even if the blocked request is older.
- R6: Buffered requests to the same line are broadcast one at a time, in the order they were accepted.
- R7: A completion received on edge k for a busy line with a waiting request causes that request to be broadcast during the cycle after edge k+1.
- R8: At most ENTRIES (default 4) lines are in flight. Further requests wait until a completion frees a slot.
- R9: `req_ready` is low while the buffer holds QDEPTH (default 8) requests, and it returns high once one of them is broadcast.
- R10: A completion is matched by transaction id alone, so completions may return in any order. A completion whose id is not in flight has no effect.
- R11: When several buffered requests become eligible, the oldest one is broadcast first, with at most one broadcast per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with `req_valid` |
| req_node | input | $clog2(NODES) | Requesting node |
| req_line | input | LINE_W | Line address |
| req_txn | input | TXN_W | Transaction id, unique among those in flight |
| bc_valid | output | 1 | Broadcast pulse |
| bc_line | output | LINE_W | Line of the broadcast request |
| bc_txn | output | TXN_W | Transaction id of the broadcast request |
| bc_src | output | $clog2(NODES) | Source node of the broadcast request |
| bc_mask | output | NODES | Destination nodes |
| cmp_valid | input | 1 | Completion present |
| cmp_txn | input | TXN_W | Transaction id being completed |

## Verification
Each fault in the internal state shows up at the broadcast port within a few cycles of the event that triggers it. If a busy entry is never cleared, a waiting request misses its slot two cycles after its completion. If the line lookup is wrong, two broadcasts for one line appear with no completion between them. If the buffer shifts incorrectly, transactions come out in the wrong order, or come out twice, or a wrong line is paired with a transaction id. If the occupancy count is wrong, `req_ready` falls one request early or late. The directed scenarios pin down the exact cycle of each broadcast relative to the stimulus that released it, so these faults are seen as wrong timing or wrong fields, not only as a missing broadcast.

// File: rtl/coh_op_pkg.sv
package coh_op_pkg;

  localparam int MAX_NODES = 64;

  // index width for a count of n items (at least one bit)
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // destination set: every node present, minus the requester
  function automatic logic [MAX_NODES-1:0] dest_mask(input int nodes, input int src);
    logic [MAX_NODES-1:0] m;
    for (int i = 0; i < MAX_NODES; i++) m[i] = (i < nodes) && (i != src);
    return m;
  endfunction

endpackage

// File: rtl/coh_req_queue.sv
module coh_req_queue
  import coh_op_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int LINE_W = 16,
  parameter int NODE_W = 2,
  parameter int TXN_W  = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push_i,
  input  logic [LINE_W-1:0]              push_line_i,
  input  logic [NODE_W-1:0]              push_node_i,
  input  logic [TXN_W-1:0]               push_txn_i,
  input  logic                           pop_i,
  input  logic [idx_w(DEPTH)-1:0]        pop_idx_i,
  output logic [DEPTH-1:0]               vld_o,
  output logic [DEPTH-1:0][LINE_W-1:0]   line_o,
  output logic [DEPTH-1:0][NODE_W-1:0]   node_o,
  output logic [DEPTH-1:0][TXN_W-1:0]    txn_o,
  output logic                           full_o
);

  localparam int IDX_W = idx_w(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  // slot 0 is always the oldest entry; valid slots are contiguous from 0
  logic [DEPTH-1:0]              vld_q, vld_n;
  logic [DEPTH-1:0][LINE_W-1:0]  line_q, line_n;
  logic [DEPTH-1:0][NODE_W-1:0]  node_q, node_n;
  logic [DEPTH-1:0][TXN_W-1:0]   txn_q, txn_n;
  logic [CNT_W-1:0]              cnt_q, cnt_n, tail;

  always_comb begin
    vld_n  = vld_q;
    line_n = line_q;
    node_n = node_q;
    txn_n  = txn_q;
    if (pop_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i >= int'(pop_idx_i)) begin
          vld_n[i]  = vld_q[(i + 1) % DEPTH];
          line_n[i] = line_q[(i + 1) % DEPTH];
          node_n[i] = node_q[(i + 1) % DEPTH];
          txn_n[i]  = txn_q[(i + 1) % DEPTH];
          if (i == DEPTH - 1) vld_n[i] = 1'b0;
        end
      end
    end
    tail = pop_i ? cnt_q - CNT_W'(1) : cnt_q;
    if (push_i) begin
      vld_n[IDX_W'(tail)]  = 1'b1;
      line_n[IDX_W'(tail)] = push_line_i;
      node_n[IDX_W'(tail)] = push_node_i;
      txn_n[IDX_W'(tail)]  = push_txn_i;
    end
    cnt_n = cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      cnt_q <= '0;
    end else begin
      vld_q <= vld_n;
      cnt_q <= cnt_n;
    end
    line_q <= line_n;
    node_q <= node_n;
    txn_q  <= txn_n;
  end

  assign vld_o  = vld_q;
  assign line_o = line_q;
  assign node_o = node_q;
  assign txn_o  = txn_q;
  assign full_o = (cnt_q == CNT_W'(DEPTH));

  // R9
  q_push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (!full_o || pop_i));

  // R11
  q_pop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> vld_q[pop_idx_i]);

  // R9
  q_count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) == $countones(vld_q));

endmodule

// File: rtl/coh_line_table.sv
module coh_line_table
  import coh_op_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int QDEPTH  = 8,
  parameter int LINE_W  = 16,
  parameter int TXN_W   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          alloc_i,
  input  logic [LINE_W-1:0]             alloc_line_i,
  input  logic [TXN_W-1:0]              alloc_txn_i,
  input  logic                          cmp_valid_i,
  input  logic [TXN_W-1:0]              cmp_txn_i,
  input  logic [QDEPTH-1:0][LINE_W-1:0] probe_line_i,
  output logic [QDEPTH-1:0]             probe_busy_o,
  output logic                          full_o
);

  localparam int E_IDX_W = idx_w(ENTRIES);

  logic [ENTRIES-1:0]              ev_q, ev_n, hit;
  logic [ENTRIES-1:0][LINE_W-1:0]  el_q;
  logic [ENTRIES-1:0][TXN_W-1:0]   et_q;
  logic [E_IDX_W-1:0]              free_idx;
  logic                            cmp_hit;

  function automatic logic [E_IDX_W-1:0] first_free(input logic [ENTRIES-1:0] v);
    logic [E_IDX_W-1:0] r;
    r = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) if (!v[i]) r = E_IDX_W'(i);
    return r;
  endfunction

  always_comb begin
    for (int e = 0; e < ENTRIES; e++)
      hit[e] = ev_q[e] && cmp_valid_i && (et_q[e] == cmp_txn_i);
    cmp_hit  = |hit;
    free_idx = first_free(ev_q);
    ev_n     = ev_q & ~hit;
    if (alloc_i) ev_n[free_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ev_q <= '0;
    else        ev_q <= ev_n;
    if (alloc_i) begin
      el_q[free_idx] <= alloc_line_i;
      et_q[free_idx] <= alloc_txn_i;
    end
  end

  for (genvar q = 0; q < QDEPTH; q++) begin : g_probe
    always_comb begin
      probe_busy_o[q] = 1'b0;
      for (int e = 0; e < ENTRIES; e++)
        if (ev_q[e] && (el_q[e] == probe_line_i[q])) probe_busy_o[q] = 1'b1;
    end
  end

  assign full_o = &ev_q;

  // R8
  tbl_no_alloc_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |-> !full_o);

  // R10
  tbl_occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(ev_q) ==
             $countones($past(ev_q)) + int'($past(alloc_i)) - int'($past(cmp_hit)));

endmodule

// File: rtl/coh_issue_arb.sv
module coh_issue_arb
  import coh_op_pkg::*;
#(
  parameter int QDEPTH = 8
) (
  input  logic [QDEPTH-1:0]        q_vld_i,
  input  logic [QDEPTH-1:0]        q_busy_i,
  input  logic                     tbl_full_i,
  output logic                     issue_o,
  output logic [idx_w(QDEPTH)-1:0] idx_o
);

  localparam int Q_IDX_W = idx_w(QDEPTH);

  logic [QDEPTH-1:0] elig;

  // lowest set bit wins: slot 0 holds the oldest request
  function automatic logic [Q_IDX_W-1:0] oldest(input logic [QDEPTH-1:0] v);
    logic [Q_IDX_W-1:0] r;
    r = '0;
    for (int i = QDEPTH - 1; i >= 0; i--) if (v[i]) r = Q_IDX_W'(i);
    return r;
  endfunction

  always_comb begin
    elig    = q_vld_i & ~q_busy_i & {QDEPTH{!tbl_full_i}};
    issue_o = |elig;
    idx_o   = oldest(elig);
  end

endmodule

// File: rtl/coh_order_point.sv
module coh_order_point
  import coh_op_pkg::*;
#(
  parameter int NODES   = 4,
  parameter int LINE_W  = 16,
  parameter int TXN_W   = 4,
  parameter int ENTRIES = 4,
  parameter int QDEPTH  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [idx_w(NODES)-1:0]    req_node,
  input  logic [LINE_W-1:0]          req_line,
  input  logic [TXN_W-1:0]           req_txn,
  output logic                       bc_valid,
  output logic [LINE_W-1:0]          bc_line,
  output logic [TXN_W-1:0]           bc_txn,
  output logic [idx_w(NODES)-1:0]    bc_src,
  output logic [NODES-1:0]           bc_mask,
  input  logic                       cmp_valid,
  input  logic [TXN_W-1:0]           cmp_txn
);

  localparam int NODE_W  = idx_w(NODES);
  localparam int Q_IDX_W = idx_w(QDEPTH);

  logic                          q_push, q_full, issue;
  logic [Q_IDX_W-1:0]            sel_idx;
  logic [QDEPTH-1:0]             q_vld, q_busy;
  logic [QDEPTH-1:0][LINE_W-1:0] q_line;
  logic [QDEPTH-1:0][NODE_W-1:0] q_node;
  logic [QDEPTH-1:0][TXN_W-1:0]  q_txn;
  logic                          tbl_full;
  logic [MAX_NODES-1:0]          mask_full;

  assign req_ready = !q_full;
  assign q_push    = req_valid && req_ready;

  coh_req_queue #(
    .DEPTH(QDEPTH), .LINE_W(LINE_W), .NODE_W(NODE_W), .TXN_W(TXN_W)
  ) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push_i(q_push), .push_line_i(req_line), .push_node_i(req_node), .push_txn_i(req_txn),
    .pop_i(issue), .pop_idx_i(sel_idx),
    .vld_o(q_vld), .line_o(q_line), .node_o(q_node), .txn_o(q_txn), .full_o(q_full)
  );

  coh_line_table #(
    .ENTRIES(ENTRIES), .QDEPTH(QDEPTH), .LINE_W(LINE_W), .TXN_W(TXN_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .alloc_i(issue), .alloc_line_i(q_line[sel_idx]), .alloc_txn_i(q_txn[sel_idx]),
    .cmp_valid_i(cmp_valid), .cmp_txn_i(cmp_txn),
    .probe_line_i(q_line), .probe_busy_o(q_busy), .full_o(tbl_full)
  );

  coh_issue_arb #(.QDEPTH(QDEPTH)) u_arb (
    .q_vld_i(q_vld), .q_busy_i(q_busy), .tbl_full_i(tbl_full),
    .issue_o(issue), .idx_o(sel_idx)
  );

  always_comb mask_full = dest_mask(NODES, int'(q_node[sel_idx]));

  always_ff @(posedge clk) begin
    if (!rst_n) bc_valid <= 1'b0;
    else        bc_valid <= issue;
    if (issue) begin
      bc_line <= q_line[sel_idx];
      bc_txn  <= q_txn[sel_idx];
      bc_src  <= q_node[sel_idx];
      bc_mask <= mask_full[NODES-1:0];
    end
  end

  // R4
  issue_line_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !q_busy[sel_idx]);

  // R2
  bc_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bc_valid |-> (($countones(bc_mask) == NODES - 1) && !bc_mask[bc_src]));

endmodule

// File: tb/coh_order_point_tb_top.sv
module coh_order_point_tb_top;

  localparam int NODES = 4, LINE_W = 16, TXN_W = 4, ENTRIES = 4, QDEPTH = 8;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_node = '0;
  logic [LINE_W-1:0] req_line = '0;
  logic [TXN_W-1:0] req_txn = '0;
  logic bc_valid;
  logic [LINE_W-1:0] bc_line;
  logic [TXN_W-1:0] bc_txn;
  logic [1:0] bc_src;
  logic [NODES-1:0] bc_mask;
  logic cmp_valid = 1'b0;
  logic [TXN_W-1:0] cmp_txn = '0;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int log_n = 0;
  int log_line [512];
  int log_txn  [512];
  int log_src  [512];
  int log_mask [512];
  int log_cyc  [512];

  always #4 clk = ~clk;

  coh_order_point #(
    .NODES(NODES), .LINE_W(LINE_W), .TXN_W(TXN_W), .ENTRIES(ENTRIES), .QDEPTH(QDEPTH)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_node(req_node),
    .req_line(req_line), .req_txn(req_txn),
    .bc_valid(bc_valid), .bc_line(bc_line), .bc_txn(bc_txn), .bc_src(bc_src),
    .bc_mask(bc_mask), .cmp_valid(cmp_valid), .cmp_txn(cmp_txn)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (bc_valid && log_n < 512) begin
      log_line[log_n] = int'(bc_line);
      log_txn[log_n]  = int'(bc_txn);
      log_src[log_n]  = int'(bc_src);
      log_mask[log_n] = int'(bc_mask);
      log_cyc[log_n]  = cyc;
      log_n = log_n + 1;
    end
  end

  always @(posedge clk) begin
    if (cyc > LIMIT && !done) begin
      done = 1'b1;
      fails = fails + 1;
      $display("FAIL watchdog: run exceeded %0d cycles (actual %0d, expected <= %0d)", LIMIT, cyc, LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // returns the cycle stamp at which it was driven
  task automatic send(input int node, input int line, input int txn, output int dc);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_node  = 2'(node);
    req_line  = LINE_W'(line);
    req_txn   = TXN_W'(txn);
    dc = cyc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic complete(input int txn, output int dc);
    cmp_valid = 1'b1;
    cmp_txn   = TXN_W'(txn);
    dc = cyc;
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  function automatic int find(input int base, input int txn);
    for (int i = base; i < log_n; i++) if (log_txn[i] == txn) return i;
    return -1;
  endfunction

  function automatic int count_txn(input int base, input int txn);
    int c = 0;
    for (int i = base; i < log_n; i++) if (log_txn[i] == txn) c++;
    return c;
  endfunction

  task automatic exp_bc(input int base, input int txn, input int line, input int src,
                        input int ecyc, input string tag);
    int k;
    int m;
    k = find(base, txn);
    m = ((1 << NODES) - 1) & ~(1 << src);
    check(k >= 0, {tag, " broadcast present"}, k, base);
    if (k >= 0) begin
      check(log_line[k] == line, {tag, " line"}, log_line[k], line);
      check(log_src[k] == src, {tag, " source"}, log_src[k], src);
      check(log_mask[k] == m, {tag, " mask"}, log_mask[k], m);
      if (ecyc >= 0) check(log_cyc[k] == ecyc, {tag, " cycle"}, log_cyc[k], ecyc);
    end
  endtask

  task automatic exp_none(input int base, input int txn, input string tag);
    int k;
    k = find(base, txn);
    check(k < 0, {tag, " no broadcast yet"}, k, -1);
  endtask

  task automatic t_reset;
    check(bc_valid == 1'b0, "R1 bc_valid idle", int'(bc_valid), 0);
    check(req_ready == 1'b1, "R1 req_ready high", int'(req_ready), 1);
  endtask

  task automatic t_single;
    int b, d, c;
    b = log_n;
    send(1, 'h10, 1, d);
    wait_cyc(5);
    exp_bc(b, 1, 'h10, 1, d + 2, "R2 R3 single");
    check(count_txn(b, 1) == 1, "R3 one-cycle pulse", count_txn(b, 1), 1);
    complete(1, c);
    wait_cyc(2);
  endtask

  task automatic t_same_line;
    int b, d0, d1, d2, c;
    b = log_n;
    send(0, 'h20, 2, d0);
    send(2, 'h20, 3, d1);
    send(3, 'h20, 4, d2);
    wait_cyc(8);
    exp_bc(b, 2, 'h20, 0, d0 + 2, "R2 first of line");
    exp_none(b, 3, "R4 held behind busy line");
    complete(9, c);
    wait_cyc(6);
    exp_none(b, 3, "R10 unknown completion ignored");
    complete(2, c);
    wait_cyc(4);
    exp_bc(b, 3, 'h20, 2, c + 2, "R7 release after completion");
    exp_none(b, 4, "R6 third waits for second");
    complete(3, c);
    wait_cyc(4);
    exp_bc(b, 4, 'h20, 3, c + 2, "R6 arrival order");
    complete(4, c);
    wait_cyc(2);
  endtask

  task automatic t_other_lines;
    int b, d0, d1, d2, c;
    b = log_n;
    send(1, 'h30, 5, d0);
    send(2, 'h30, 6, d1);
    send(3, 'h40, 7, d2);
    wait_cyc(6);
    exp_bc(b, 7, 'h40, 3, d2 + 2, "R5 other line overtakes");
    exp_none(b, 6, "R4 same line blocked");
    complete(7, c);
    wait_cyc(3);
    exp_none(b, 6, "R10 completion for other txn");
    complete(5, c);
    wait_cyc(4);
    exp_bc(b, 6, 'h30, 2, c + 2, "R10 out-of-order completion");
    complete(6, c);
    wait_cyc(2);
  endtask

  task automatic t_table_full;
    int b, d, c;
    b = log_n;
    for (int i = 0; i < ENTRIES; i++) send(i % NODES, 'h50 + i, 1 + i, d);
    send(2, 'h54, 5, d);
    wait_cyc(8);
    check(log_n - b == ENTRIES, "R8 in-flight limit", log_n - b, ENTRIES);
    exp_none(b, 5, "R8 fifth line held");
    complete(3, c);
    wait_cyc(4);
    exp_bc(b, 5, 'h54, 2, c + 2, "R8 slot freed");
    complete(1, c); complete(2, c); complete(4, c); complete(5, c);
    wait_cyc(2);
  endtask

  task automatic t_backpressure;
    int b, d, c, k;
    b = log_n;
    for (int i = 0; i < ENTRIES; i++) send(0, 'h60 + i, 1 + i, d);
    for (int i = 0; i < QDEPTH; i++) send(1, 'h60, 5 + i, d);
    wait_cyc(1);
    check(req_ready == 1'b0, "R9 ready low when full", int'(req_ready), 0);
    wait_cyc(5);
    check(req_ready == 1'b0, "R9 ready stays low", int'(req_ready), 0);
    complete(1, c);
    wait_cyc(3);
    check(req_ready == 1'b1, "R9 ready back", int'(req_ready), 1);
    exp_bc(b, 5, 'h60, 1, c + 2, "R9 head released");
    complete(2, c); complete(3, c); complete(4, c);
    for (int t = 5; t < 5 + QDEPTH - 1; t++) begin
      complete(t, c);
      wait_cyc(4);
      k = find(b, t + 1);
      check(k >= 0 && log_cyc[k] == c + 2, "R6 serial release",
            (k >= 0) ? log_cyc[k] : -1, c + 2);
    end
    complete(5 + QDEPTH - 1, c);
    wait_cyc(2);
  endtask

  task automatic t_oldest;
    int b, d, c;
    b = log_n;
    for (int i = 0; i < ENTRIES; i++) send(3, 'h70 + i, 1 + i, d);
    send(0, 'h80, 5, d);
    send(1, 'h81, 6, d);
    send(2, 'h82, 7, d);
    wait_cyc(6);
    complete(1, c);
    wait_cyc(4);
    exp_bc(b, 5, 'h80, 0, c + 2, "R11 oldest first");
    exp_none(b, 6, "R11 younger waits");
    complete(2, c);
    wait_cyc(4);
    exp_bc(b, 6, 'h81, 1, c + 2, "R11 next oldest");
    complete(3, c);
    wait_cyc(4);
    exp_bc(b, 7, 'h82, 2, c + 2, "R11 last");
    complete(4, c); complete(5, c); complete(6, c); complete(7, c);
    wait_cyc(2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_same_line();
    t_other_lines();
    t_table_full();
    t_backpressure();
    t_oldest();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule